// File: doc/BRIEF.md
# Reset Cause Status Register

This block is an 8-bit status register that tells software why the processor core last came out of reset. It watches two cause indications. One comes from the external reset input, when an outside device pulls reset. The other comes from the core watchdog timer. It also watches a strobe from the reset sequencer that marks the end of a reset sequence. A cause indication arms a small tracking state machine. The register itself changes only when the completion strobe arrives. At that point the collected causes are reduced to a single one-hot value, and that value replaces whatever the register held before.

The register is cleared only by the power-on reset input, `por_n`. It is not cleared by the core reset it reports, so the recorded cause survives into the software that runs afterwards. Software reads the register through a single select line. It clears a cause bit by writing 1 to that bit. Bit 7 flags an external reset and bit 5 flags a watchdog reset. All other bits are reserved: they read as 0 and ignore writes.

The tracking state machine has two states:
- `ST_RUN`: normal operation, with nothing pending. A cause flag in this state moves it to `ST_ARMED` (transition *arm*). A cause flag together with the completion strobe commits at once and stays in `ST_RUN` (transition *direct commit*).
- `ST_ARMED`: a reset is in progress. Further cause flags are added to the pending set. The completion strobe commits the pending set and returns to `ST_RUN` (transition *complete*). Without the strobe the machine stays in `ST_ARMED` (transition *hold*).

Top module: `rst_cause_reg`

## Requirements
- R1: After `por_n` is low, the register reads 0x00.
- R2: An external cause followed by completion makes the register read 0x80 (bit 7 only) from the cycle after the completion strobe.
- R3: A watchdog cause followed by completion makes the register read 0x20 (bit 5 only) from the cycle after the completion strobe.
- R4: If both causes are pending when completion arrives, the external cause wins and the register reads 0x80.
- R5: While a reset is in progress and before the completion strobe, the register keeps its earlier value.
- R6: At most one bit is ever set, and a newly committed cause replaces any earlier one.
- R7: Writing 1 to a set cause bit clears it. Writing 0 to a bit leaves it unchanged.
- R8: Reserved bits (every bit except 7 and 5) always read 0, including after writes of 1 to them.
- R9: When a commit and a software write fall in the same cycle, the committed cause is what the register holds afterwards.
- R10: A completion strobe with no cause pending leaves the register unchanged.
- R11: `reg_rdata` reads 0 while `reg_sel` is low.
- R12: A cause flag that drops again before completion is still recorded at completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low; the only input that clears the register |
| ext_rst_flag | input | 1 | External reset source is active |
| wdt_rst_flag | input | 1 | Core watchdog reset source is active |
| rst_seq_done | input | 1 | One-cycle strobe from the sequencer at the end of a reset |
| reg_sel | input | 1 | Register select for read and write |
| reg_wr | input | 1 | Write enable, used together with `reg_sel` |
| reg_wdata | input | 8 | Write data; a 1 clears the matching cause bit |
| reg_rdata | output | 8 | Register contents while selected, otherwise 0 |

## Verification
The assertions rely on two assumptions about the inputs. First, `rst_seq_done` is a single-cycle strobe. Second, the cause flags are meaningful only between the start of a reset and its completion strobe. Beyond that they allow any mix of flags, strobes and writes in the same cycle. The bench changes every input on the falling clock edge. It raises flags either before the strobe or together with it, never in any other pattern. It reads the result on the falling edge after the capturing rising edge. The bench also drives the same-cycle collisions on purpose: both causes at once, and a commit together with a write.

// File: rtl/rst_cause_pkg.sv
package rst_cause_pkg;

    typedef enum logic [0:0] {
        ST_RUN   = 1'b0,
        ST_ARMED = 1'b1
    } trk_state_t;

    typedef struct packed {
        logic ext;
        logic wdt;
    } cause_t;

    localparam cause_t CAUSE_NONE = '{ext: 1'b0, wdt: 1'b0};

endpackage

// File: rtl/rst_cause_track.sv
module rst_cause_track
    import rst_cause_pkg::*;
(
    input  logic   clk,
    input  logic   por_n,
    input  logic   ext_flag_i,
    input  logic   wdt_flag_i,
    input  logic   done_i,
    output logic   commit_o,
    output cause_t commit_cause_o
);

    trk_state_t state_q, state_d;
    cause_t     pend_q, pend_d;
    cause_t     now_c, seen_c;
    logic       any_now;

    always_comb begin
        now_c.ext = ext_flag_i;
        now_c.wdt = wdt_flag_i;
        any_now   = ext_flag_i | wdt_flag_i;
        seen_c    = pend_q | now_c;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        pend_d  = pend_q;
        unique case (state_q)
            ST_RUN: begin
                if (any_now && !done_i) begin
                    state_d = ST_ARMED;   // arm
                    pend_d  = now_c;
                end else begin
                    pend_d  = CAUSE_NONE; // idle or direct commit
                end
            end
            ST_ARMED: begin
                if (done_i) begin
                    state_d = ST_RUN;     // complete
                    pend_d  = CAUSE_NONE;
                end else begin
                    pend_d  = seen_c;     // hold
                end
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            state_q <= ST_RUN;
            pend_q  <= CAUSE_NONE;
        end else begin
            state_q <= state_d;
            pend_q  <= pend_d;
        end
    end

    // outputs
    always_comb begin
        commit_o       = 1'b0;
        commit_cause_o = CAUSE_NONE;
        unique case (state_q)
            ST_RUN: begin
                commit_o       = done_i && any_now;
                commit_cause_o = now_c;
            end
            ST_ARMED: begin
                commit_o       = done_i;
                commit_cause_o = seen_c;
            end
        endcase
    end

    AST_ARM_ON_FLAG: assert property (@(posedge clk) disable iff (!por_n)
        (state_q == ST_RUN && any_now && !done_i) |=> (state_q == ST_ARMED)); // R5
    AST_PEND_KEPT: assert property (@(posedge clk) disable iff (!por_n)
        (state_q == ST_ARMED && !done_i) |=> (state_q == ST_ARMED && (pend_q.ext || pend_q.wdt))); // R12
    AST_COMMIT_HAS_CAUSE: assert property (@(posedge clk) disable iff (!por_n)
        commit_o |-> (commit_cause_o.ext || commit_cause_o.wdt)); // R10

endmodule

// File: rtl/rst_cause_prio.sv
module rst_cause_prio
    import rst_cause_pkg::*;
#(
    parameter int unsigned REG_W   = 8,
    parameter int unsigned EXT_POS = 7,
    parameter int unsigned WDT_POS = 5
) (
    input  logic             clk,
    input  logic             por_n,
    input  cause_t           cause_i,
    output logic [REG_W-1:0] vec_o
);

    for (genvar gi = 0; gi < REG_W; gi++) begin : g_bit
        if (gi == EXT_POS) begin : g_ext
            assign vec_o[gi] = cause_i.ext;
        end else if (gi == WDT_POS) begin : g_wdt
            assign vec_o[gi] = cause_i.wdt & ~cause_i.ext;
        end else begin : g_rsvd
            assign vec_o[gi] = 1'b0;
        end
    end

    AST_EXT_WINS: assert property (@(posedge clk) disable iff (!por_n)
        (cause_i.ext && cause_i.wdt) |-> (vec_o == (REG_W'(1) << EXT_POS))); // R4
    AST_VEC_ONEHOT: assert property (@(posedge clk) disable iff (!por_n)
        $onehot0(vec_o)); // R6

endmodule

// File: rtl/rst_cause_store.sv
module rst_cause_store #(
    parameter int unsigned      REG_W      = 8,
    parameter logic [REG_W-1:0] VALID_MASK = 8'hA0
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic             commit_i,
    input  logic [REG_W-1:0] cause_vec_i,
    input  logic             wr_i,
    input  logic [REG_W-1:0] wdata_i,
    output logic [REG_W-1:0] status_o
);

    logic [REG_W-1:0] status_q, status_d;

    always_comb begin
        status_d = status_q;
        if (commit_i) begin
            status_d = cause_vec_i;
        end else if (wr_i) begin
            status_d = status_q & ~(wdata_i & VALID_MASK);
        end
        status_d = status_d & VALID_MASK;
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) status_q <= '0;
        else        status_q <= status_d;
    end

    assign status_o = status_q;

    AST_STATUS_ONEHOT: assert property (@(posedge clk) disable iff (!por_n)
        $onehot0(status_q)); // R6
    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!por_n)
        ((status_q & ~VALID_MASK) == '0)); // R8
    AST_CAPTURE_WINS: assert property (@(posedge clk) disable iff (!por_n)
        commit_i |=> (status_q == $past(cause_vec_i))); // R9
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!por_n)
        (!commit_i && !wr_i) |=> $stable(status_q)); // R5
    AST_ZERO_WRITE_KEEPS: assert property (@(posedge clk) disable iff (!por_n)
        (!commit_i && wr_i && ((wdata_i & status_q) == '0)) |=> $stable(status_q)); // R7

endmodule

// File: rtl/rst_cause_reg.sv
module rst_cause_reg
    import rst_cause_pkg::*;
#(
    parameter int unsigned REG_W   = 8,
    parameter int unsigned EXT_POS = 7,
    parameter int unsigned WDT_POS = 5
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic             ext_rst_flag,
    input  logic             wdt_rst_flag,
    input  logic             rst_seq_done,
    input  logic             reg_sel,
    input  logic             reg_wr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata
);

    localparam logic [REG_W-1:0] VALID_MASK =
        (REG_W'(1) << EXT_POS) | (REG_W'(1) << WDT_POS);

    logic             commit;
    cause_t           commit_cause;
    logic [REG_W-1:0] cause_vec;
    logic [REG_W-1:0] status;
    logic             wr_hit;

    assign wr_hit = reg_sel & reg_wr;

    rst_cause_track u_track (
        .clk            (clk),
        .por_n          (por_n),
        .ext_flag_i     (ext_rst_flag),
        .wdt_flag_i     (wdt_rst_flag),
        .done_i         (rst_seq_done),
        .commit_o       (commit),
        .commit_cause_o (commit_cause)
    );

    rst_cause_prio #(
        .REG_W   (REG_W),
        .EXT_POS (EXT_POS),
        .WDT_POS (WDT_POS)
    ) u_prio (
        .clk     (clk),
        .por_n   (por_n),
        .cause_i (commit_cause),
        .vec_o   (cause_vec)
    );

    rst_cause_store #(
        .REG_W      (REG_W),
        .VALID_MASK (VALID_MASK)
    ) u_store (
        .clk         (clk),
        .por_n       (por_n),
        .commit_i    (commit),
        .cause_vec_i (cause_vec),
        .wr_i        (wr_hit),
        .wdata_i     (reg_wdata),
        .status_o    (status)
    );

    assign reg_rdata = reg_sel ? status : '0;

    AST_DONE_ALONE_HOLDS: assert property (@(posedge clk) disable iff (!por_n)
        (rst_seq_done && !commit && !wr_hit) |=> $stable(status)); // R10
    AST_EXT_COMMIT: assert property (@(posedge clk) disable iff (!por_n)
        (commit && commit_cause.ext) |=> (status == (REG_W'(1) << EXT_POS))); // R2
    AST_WDT_COMMIT: assert property (@(posedge clk) disable iff (!por_n)
        (commit && commit_cause.wdt && !commit_cause.ext) |=> (status == (REG_W'(1) << WDT_POS))); // R3

endmodule

// File: tb/rst_cause_reg_tb.sv
`timescale 1ns/1ps
module rst_cause_reg_tb_top;

    logic       clk = 1'b0;
    logic       por_n = 1'b0;
    logic       ext_rst_flag = 1'b0;
    logic       wdt_rst_flag = 1'b0;
    logic       rst_seq_done = 1'b0;
    logic       reg_sel = 1'b1;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    rst_cause_reg dut_i (
        .clk          (clk),
        .por_n        (por_n),
        .ext_rst_flag (ext_rst_flag),
        .wdt_rst_flag (wdt_rst_flag),
        .rst_seq_done (rst_seq_done),
        .reg_sel      (reg_sel),
        .reg_wr       (reg_wr),
        .reg_wdata    (reg_wdata),
        .reg_rdata    (reg_rdata)
    );

    task automatic check(string req, logic [7:0] exp);
        checks++;
        if (reg_rdata !== exp) begin
            errors++;
            $display("FAIL %s: rdata=%02h expected=%02h", req, reg_rdata, exp);
        end
    endtask

    // complete a reset with the given flags raised in the strobe cycle
    task automatic finish_reset(logic ext, logic wdt);
        @(negedge clk);
        ext_rst_flag = ext; wdt_rst_flag = wdt; rst_seq_done = 1'b1;
        @(negedge clk);
        ext_rst_flag = 1'b0; wdt_rst_flag = 1'b0; rst_seq_done = 1'b0;
    endtask

    task automatic sw_write(logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = 8'h00;
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        check("R1", 8'h00);
        por_n = 1'b1;
        @(negedge clk);
        check("R1", 8'h00);
    endtask

    task automatic t_ext();
        finish_reset(1'b1, 1'b0);
        check("R2", 8'h80);
    endtask

    task automatic t_wdt_replace();
        finish_reset(1'b0, 1'b1);
        check("R3", 8'h20);
        check("R6", 8'h20);
    endtask

    task automatic t_pending_hold();
        // register holds 0x20; external flag pulses, then completion later
        @(negedge clk); ext_rst_flag = 1'b1;
        @(negedge clk); ext_rst_flag = 1'b0;
        check("R5", 8'h20);
        repeat (4) @(negedge clk);
        check("R5", 8'h20);
        finish_reset(1'b0, 1'b0);
        check("R12", 8'h80);
    endtask

    task automatic t_both();
        finish_reset(1'b1, 1'b1);
        check("R4", 8'h80);
        // watchdog armed earlier, external arrives with completion
        @(negedge clk); wdt_rst_flag = 1'b1;
        @(negedge clk); wdt_rst_flag = 1'b0;
        finish_reset(1'b1, 1'b0);
        check("R4", 8'h80);
    endtask

    task automatic t_w1c();
        sw_write(8'h00);
        check("R7", 8'h80);
        sw_write(8'h5F);
        check("R8", 8'h80);
        sw_write(8'h80);
        check("R7", 8'h00);
        sw_write(8'hFF);
        check("R8", 8'h00);
    endtask

    task automatic t_collide();
        finish_reset(1'b1, 1'b0);
        @(negedge clk);
        wdt_rst_flag = 1'b1; rst_seq_done = 1'b1; reg_wr = 1'b1; reg_wdata = 8'hFF;
        @(negedge clk);
        wdt_rst_flag = 1'b0; rst_seq_done = 1'b0; reg_wr = 1'b0; reg_wdata = 8'h00;
        check("R9", 8'h20);
    endtask

    task automatic t_bare_done();
        finish_reset(1'b0, 1'b0);
        check("R10", 8'h20);
        sw_write(8'h20);
        finish_reset(1'b0, 1'b0);
        check("R10", 8'h00);
    endtask

    task automatic t_deselect();
        finish_reset(1'b1, 1'b0);
        @(negedge clk); reg_sel = 1'b0;
        #1 check("R11", 8'h00);
        // write strobe while deselected must not clear
        reg_wr = 1'b1; reg_wdata = 8'hFF;
        @(negedge clk); reg_wr = 1'b0; reg_sel = 1'b1;
        #1 check("R11", 8'h80);
    endtask

    initial begin
        t_reset();
        t_ext();
        t_wdt_replace();
        t_pending_hold();
        t_both();
        t_w1c();
        t_collide();
        t_bare_done();
        t_deselect();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: run did not finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule